// File: doc/BRIEF.md
# ADC Result Queue with Status Word

This block sits between a 12-bit analog-to-digital converter and the processor's register bus. Every finished conversion is pushed, together with its polarity bit, into a small first-in first-out queue of four entries. Software sees only the oldest entry. It sees it through one 16-bit read-only word, which also carries a valid flag, a sticky flag for lost conversions and the live level of a pen-contact sense line.

A read strobe on the word removes the oldest entry and clears every cleared-on-read field. The pen-contact bit is the exception, because it always follows its input pin. When the queue is empty the word shows a zero result with the valid flag low. Nothing in the queue changes on a read of an empty queue.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset the queue is empty, and `rd_data` equals `{3'b000, 13'b0}` except bit 13, which follows `pen_down`.
- R2: The word layout is fixed: bit 15 valid, bit 14 overflow, bit 13 pen contact, bit 12 polarity, bits 11:0 result. Bit 15 is 1 whenever at least one entry is held.
- R3: Entries leave in the order they arrived. Each read strobe removes exactly one entry, and the queue holds at most 4 entries.
- R4: When bit 15 is 0, bits 12 and 11:0 read as 0. A read strobe on an empty queue leaves the queue contents and order unchanged.
- R5: A conversion that arrives while the queue holds 4 entries, with no read in the same cycle, is discarded and sets bit 14. The entries already held stay unchanged.
- R6: A read strobe clears bit 14 in the following cycle. This holds whether the queue was empty or not.
- R7: A conversion and a read strobe in the same cycle on a full queue remove the head and store the new entry at the tail. Bit 14 is not set.
- R8: Bit 13 equals `pen_down` in every cycle and is never cleared by a read.
- R9: When `diff_mode` is 0 at the time a conversion is stored, its polarity bit is stored as 0. When `diff_mode` is 1, `conv_sign` is stored unchanged.
- R10: A conversion and a read strobe in the same cycle on an empty queue store the conversion, which becomes the head in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is offered |
| conv_result | input | 12 | Conversion result |
| conv_sign | input | 1 | Polarity of the conversion (differential mode) |
| diff_mode | input | 1 | 1: differential mode, 0: single-ended (polarity forced to 0) |
| pen_down | input | 1 | Live pen-contact level |
| rd_en | input | 1 | Read strobe on the status word; pops the head |
| rd_data | output | 16 | Status word: valid, overflow, pen contact, polarity, result |

## Verification
`rd_data` is a combinational view of registered state. The value that a read returns is therefore the one present during the cycle of the strobe, and the bench compares it after the falling edge and before the rising edge that pops. A stored conversion, a pop, a set overflow flag and a cleared overflow flag all show one rising edge later. Each check samples one time unit after that edge, with the strobes already released. Bit 13 has no register in its path, so it is compared in the same half-cycle in which `pen_down` changes.

// File: rtl/adcf_pkg.sv
// Package: shared widths, word bit positions and the stored entry type
// for the ADC result queue. The bit positions are fixed by the register
// layout that software decodes.
package adcf_pkg;
    localparam int RES_W    = 12;
    localparam int WORD_W   = 16;
    localparam int BIT_DONE = 15;
    localparam int BIT_OVF  = 14;
    localparam int BIT_PEN  = 13;
    localparam int BIT_SIGN = 12;

    typedef struct packed {
        logic             sign;
        logic [RES_W-1:0] res;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/adcf_ptrs.sv
// Module: adcf_ptrs
// Keeps the read and write pointers, the fill count and the sticky
// overflow flag. It turns the raw strobes into accepted push and pop
// events. Assumes single-cycle strobes sampled on the rising edge.
// A push into a full queue is accepted only when a pop happens in the
// same cycle.
module adcf_ptrs #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             ovf
);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    logic full;

    // Derive queue status and accepted events from the strobes.
    always_comb begin
        empty = (count == '0);
        full  = (count == FULLC);
        pop   = rd_req && !empty;
        push  = wr_req && (!full || pop);
    end

    // Advance the write pointer on each accepted push, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push)
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    end

    // Advance the read pointer on each accepted pop, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end

    // Track the number of held entries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (push && !pop)
            count <= count + 1'b1;
        else if (pop && !push)
            count <= count - 1'b1;
    end

    // Sticky overflow: set on a rejected push, cleared by any read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (rd_req)
            ovf <= 1'b0;
        else if (wr_req && !push)
            ovf <= 1'b1;
    end
endmodule

// File: rtl/adcf_store.sv
// Module: adcf_store
// Register-based entry storage with one write port and a read mux that
// selects the head. Assumes the pointers stay below DEPTH. The polarity
// is forced to 0 on store when single-ended mode is selected.
module adcf_store
    import adcf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [RES_W-1:0] in_res,
    input  logic             in_sign,
    input  logic             diff_mode,
    output entry_t           head
);
    entry_t slot [DEPTH];
    entry_t incoming;

    // Build the entry to store, masking polarity in single-ended mode.
    always_comb begin
        incoming.res  = in_res;
        incoming.sign = in_sign && diff_mode;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Load this slot when the write pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[i] <= '0;
            else if (push && (wr_ptr == PTR_W'(i)))
                slot[i] <= incoming;
        end
    end

    // Present the head entry.
    always_comb begin
        head = slot[rd_ptr];
    end
endmodule

// File: rtl/adcf_view.sv
// Module: adcf_view
// Assembles the read-only status word from the queue state. Assumes the
// head entry may hold stale data when the queue is empty, so the result
// and polarity are masked by the valid flag.
module adcf_view
    import adcf_pkg::*;
(
    input  entry_t              head,
    input  logic                empty,
    input  logic                ovf,
    input  logic                pen_down,
    output logic [WORD_W-1:0]   word
);
    // Place each field at its fixed bit position.
    always_comb begin
        word                  = '0;
        word[BIT_DONE]        = !empty;
        word[BIT_OVF]         = ovf;
        word[BIT_PEN]         = pen_down;
        word[BIT_SIGN]        = head.sign && !empty;
        word[RES_W-1:0]       = empty ? '0 : head.res;
    end
endmodule

// File: rtl/adc_result_fifo.sv
// Module: adc_result_fifo
// Top level of the ADC result queue. Conversions are pushed on
// conv_valid, and a read strobe pops the head and clears the
// cleared-on-read fields. rd_data is a combinational view of the held
// state. Assumes rd_en and conv_valid are one-cycle strobes in the clk
// domain.
module adc_result_fifo
    import adcf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [11:0]       conv_result,
    input  logic              conv_sign,
    input  logic              diff_mode,
    input  logic              pen_down,
    input  logic              rd_en,
    output logic [15:0]       rd_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             empty;
    logic             ovf;
    entry_t           head;

    adcf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (conv_valid),
        .rd_req (rd_en),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .count  (count),
        .empty  (empty),
        .ovf    (ovf)
    );

    adcf_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .in_res    (conv_result),
        .in_sign   (conv_sign),
        .diff_mode (diff_mode),
        .head      (head)
    );

    adcf_view u_view (
        .head     (head),
        .empty    (empty),
        .ovf      (ovf),
        .pen_down (pen_down),
        .word     (rd_data)
    );
endmodule

// File: rtl/adcf_checker.sv
// Module: adcf_checker
// Assertions for the ADC result queue, attached to the top by bind.
module adcf_checker #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_valid,
    input logic             conv_sign,
    input logic             diff_mode,
    input logic             pen_down,
    input logic             rd_en,
    input logic [15:0]      rd_data,
    input logic [CNT_W-1:0] count
);
    // R3: the fill count never exceeds the depth.
    assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R4: without the valid flag, polarity and result read as zero.
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> (rd_data[12:0] == 13'b0));

    // R4: a read on an empty queue with no conversion leaves it empty.
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !conv_valid && !rd_data[15]) |=> !rd_data[15]);

    // R5: a conversion into a full queue without a read sets overflow.
    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !rd_en && count == CNT_W'(DEPTH)) |=> rd_data[14]);

    // R6: any read strobe clears overflow in the next cycle.
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_data[14]);

    // R7: a conversion together with a read on a full queue keeps it full.
    assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && rd_en && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)));

    // R8: the pen contact bit follows its input.
    assert_pen_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[13] == pen_down);

    // R10: a conversion and a read on an empty queue yield a valid head.
    assert_empty_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && rd_en && !rd_data[15]) |=> rd_data[15]);
endmodule

bind adc_result_fifo adcf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_sign  (conv_sign),
    .diff_mode  (diff_mode),
    .pen_down   (pen_down),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .count      (count)
);

// File: tb/sim_adc_result_fifo.sv
// Directed bench for adc_result_fifo: one task per scenario.
module sim_adc_result_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_result = '0;
    logic        conv_sign = 1'b0;
    logic        diff_mode = 1'b1;
    logic        pen_down = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_fifo u0 (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid),
        .conv_result(conv_result), .conv_sign(conv_sign),
        .diff_mode(diff_mode), .pen_down(pen_down), .rd_en(rd_en),
        .rd_data(rd_data)
    );

    function automatic logic [15:0] w(input logic v, input logic o,
                                      input logic p, input logic s,
                                      input logic [11:0] r);
        return {v, o, p, s, r};
    endfunction

    task automatic check(input logic [15:0] exp, input string req);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    // One clock with the given strobes; the value seen before the edge is checked when asked.
    task automatic cyc(input logic wv, input logic [11:0] d, input logic s,
                       input logic rv, input bit chk, input logic [15:0] exp,
                       input string req);
        @(negedge clk);
        conv_valid = wv; conv_result = d; conv_sign = s; rd_en = rv;
        #1;
        if (chk) check(exp, req);
        @(posedge clk);
        #1;
        conv_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic push(input logic [11:0] d, input logic s);
        cyc(1'b1, d, s, 1'b0, 1'b0, '0, "");
    endtask

    task automatic pop_chk(input logic [15:0] exp, input string req);
        cyc(1'b0, '0, 1'b0, 1'b1, 1'b1, exp, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check(16'h0000, "R1");
    endtask

    task automatic t_layout();
        push(12'hABC, 1'b1);
        check(w(1, 0, 0, 1, 12'hABC), "R2");
        pop_chk(w(1, 0, 0, 1, 12'hABC), "R2");
        check(16'h0000, "R2");
    endtask

    task automatic t_order();
        for (int i = 0; i < 4; i++) push(12'h100 + 12'(i), 1'(i & 1));
        for (int i = 0; i < 4; i++)
            pop_chk(w(1, 0, 0, 1'(i & 1), 12'h100 + 12'(i)), "R3");
        check(16'h0000, "R3");
    endtask

    task automatic t_empty_read();
        pop_chk(16'h0000, "R4");
        check(16'h0000, "R4");
        push(12'h055, 1'b0);
        pop_chk(w(1, 0, 0, 0, 12'h055), "R4");
        check(16'h0000, "R4");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 4; i++) push(12'h200 + 12'(i), 1'b0);
        push(12'hFFF, 1'b1);
        check(w(1, 1, 0, 0, 12'h200), "R5");
        pop_chk(w(1, 1, 0, 0, 12'h200), "R5");
        check(w(1, 0, 0, 0, 12'h201), "R6");
        pop_chk(w(1, 0, 0, 0, 12'h201), "R6");
        pop_chk(w(1, 0, 0, 0, 12'h202), "R5");
        pop_chk(w(1, 0, 0, 0, 12'h203), "R5");
        check(16'h0000, "R5");
        for (int i = 0; i < 4; i++) push(12'h010, 1'b0);
        push(12'h020, 1'b0);
        for (int i = 0; i < 4; i++) pop_chk(w(1, (i == 0), 0, 0, 12'h010), "R6");
        push(12'h030, 1'b0);
        push(12'h031, 1'b0);
        pop_chk(w(1, 0, 0, 0, 12'h030), "R6");
        pop_chk(w(1, 0, 0, 0, 12'h031), "R6");
        check(16'h0000, "R6");
    endtask

    task automatic t_empty_read_clears_ovf();
        for (int i = 0; i < 4; i++) push(12'h040 + 12'(i), 1'b0);
        push(12'h0EE, 1'b0);
        for (int i = 0; i < 4; i++) pop_chk(w(1, (i == 0), 0, 0, 12'h040 + 12'(i)), "R6");
        check(16'h0000, "R6");
    endtask

    task automatic t_full_swap();
        for (int i = 0; i < 4; i++) push(12'h300 + 12'(i), 1'b0);
        cyc(1'b1, 12'h3AA, 1'b1, 1'b1, 1'b1, w(1, 0, 0, 0, 12'h300), "R7");
        check(w(1, 0, 0, 0, 12'h301), "R7");
        for (int i = 1; i < 4; i++) pop_chk(w(1, 0, 0, 0, 12'h300 + 12'(i)), "R7");
        pop_chk(w(1, 0, 0, 1, 12'h3AA), "R7");
        check(16'h0000, "R7");
    endtask

    task automatic t_pen();
        @(negedge clk);
        pen_down = 1'b1;
        #1 check(w(0, 0, 1, 0, 12'h0), "R8");
        pop_chk(w(0, 0, 1, 0, 12'h0), "R8");
        check(w(0, 0, 1, 0, 12'h0), "R8");
        push(12'h777, 1'b0);
        pop_chk(w(1, 0, 1, 0, 12'h777), "R8");
        check(w(0, 0, 1, 0, 12'h0), "R8");
        @(negedge clk);
        pen_down = 1'b0;
        #1 check(16'h0000, "R8");
    endtask

    task automatic t_single_ended();
        diff_mode = 1'b0;
        push(12'h5A5, 1'b1);
        diff_mode = 1'b1;
        push(12'h5A6, 1'b1);
        pop_chk(w(1, 0, 0, 0, 12'h5A5), "R9");
        pop_chk(w(1, 0, 0, 1, 12'h5A6), "R9");
    endtask

    task automatic t_empty_simul();
        cyc(1'b1, 12'h0C3, 1'b0, 1'b1, 1'b1, 16'h0000, "R10");
        check(w(1, 0, 0, 0, 12'h0C3), "R10");
        pop_chk(w(1, 0, 0, 0, 12'h0C3), "R10");
        check(16'h0000, "R10");
    endtask

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_layout();
        t_order();
        t_empty_read();
        t_overflow();
        t_empty_read_clears_ovf();
        t_full_swap();
        t_pen();
        t_single_ended();
        t_empty_simul();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule